// File: doc/BRIEF.md
# Two-Wire Serial Byte-Memory Slave

This block is the slave side of a two-wire serial bus (I2C-style clock and data lines) in front of a byte-wide memory model. The memory has a 13-bit address space. The block runs on the system clock. It synchronises the bus lines, detects start and stop conditions, and shifts bytes in and out on the bus clock edges. It pulls the data line low through an open-drain enable output, both to acknowledge and to send read data.

The first byte after a start combines three things: two device-select bits, the five upper address bits, and the read/write flag. The select bits are compared against two strap pins, so four devices can share one bus. A write sends an address byte and then one data byte. The array is not updated while the data byte arrives. The update is committed only when the master issues the stop condition. A timed internal write cycle then begins. For its whole length the block ignores the bus and raises a busy output.

A read sets the address with a write header and then switches direction with a repeated start. The block returns bytes from the array. The address advances for as long as the master acknowledges each byte.

Top module: `twowire_mem_slave`

## Requirements
- R1: After reset `sda_oe` is 0 (data line released) and `busy` is 0.
- R2: The first byte after a start matches only when its bit 7 equals the inverse of `sel_hi_pin` and its bit 6 equals `sel_lo_pin`. On a mismatch the block gives no acknowledge and ignores the bus until the next start.
- R3: The block acknowledges by driving `sda_oe` to 1 through the ninth clock that follows a matching device byte, an address byte and the first data byte. `sda_oe` changes only while the synchronised bus clock is low.
- R4: `busy` rises only after a stop that ends a write whose data byte was acknowledged. It stays low between that acknowledge and the stop.
- R5: While `busy` is 1, the block acknowledges nothing, `sda_oe` stays 0, and bus traffic cannot start another write.
- R6: A stop that arrives before the data byte has been acknowledged starts no write cycle and leaves the array unchanged.
- R7: Bit 0 of the device byte selects read (1) or write (0). Device-byte bits 5..1 form address bits 12..8 and the address byte forms bits 7..0. A random read (write header, address, repeated start, read header) returns the byte stored at that 13-bit address.
- R8: During a read, a master acknowledge after a byte makes the block send the byte at the next address. A master non-acknowledge ends the read.
- R9: Data bytes after the first in one write are not acknowledged. The stop still commits only the first byte.
- R10: `busy` stays high for exactly `WRITE_CYCLES` system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sel_hi_pin | input | 1 | Strap pin; device-byte bit 7 must be its inverse |
| sel_lo_pin | input | 1 | Strap pin; device-byte bit 6 must equal it |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| busy | output | 1 | High during the internal write cycle |

## Verification
The bench builds the block with `ARRAY_DEPTH` = 8192, so all 13 address bits are distinct and two addresses that differ only in their upper bits can be told apart. `WRITE_CYCLES` is set to 600. That is short enough to measure the busy window exactly, and long enough for a whole start and device byte to fall inside it, so the bench can check that no acknowledge is given during the write cycle. `SYNC_STAGES` keeps its default of 2, and each bus bit lasts 32 system clocks, which leaves margin for the synchroniser latency.

// File: rtl/twm_pkg.sv
package twm_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned HI_W   = 5;
   localparam int unsigned ADDR_W = HI_W + BYTE_W;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_DEV_ACK,
      ST_ADR,
      ST_ADR_ACK,
      ST_DAT,
      ST_DAT_ACK,
      ST_RD,
      ST_RD_ACK,
      ST_IGNORE
   } twm_state_e;

   typedef struct packed {
      logic start;
      logic stop;
      logic rise;
      logic fall;
      logic sda;
   } bus_evt_t;
endpackage

// File: rtl/twm_sync.sv
module twm_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   output twm_pkg::bus_evt_t evt,
   output logic              scl_lvl
);
   logic scl_s, sda_s, scl_q, sda_q;

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("twm_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_single
         logic scl_r, sda_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_r <= 1'b1;
               sda_r <= 1'b1;
            end else begin
               scl_r <= scl_in;
               sda_r <= sda_in;
            end
         end
         assign scl_s = scl_r;
         assign sda_s = sda_r;
      end else begin : g_chain
         logic [STAGES-1:0] scl_sh, sda_sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_sh <= '1;
               sda_sh <= '1;
            end else begin
               scl_sh <= {scl_sh[STAGES-2:0], scl_in};
               sda_sh <= {sda_sh[STAGES-2:0], sda_in};
            end
         end
         assign scl_s = scl_sh[STAGES-1];
         assign sda_s = sda_sh[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign evt.start = scl_s & scl_q & sda_q & ~sda_s;
   assign evt.stop  = scl_s & scl_q & ~sda_q & sda_s;
   assign evt.rise  = scl_s & ~scl_q;
   assign evt.fall  = ~scl_s & scl_q;
   assign evt.sda   = sda_s;
   assign scl_lvl   = scl_s;
endmodule

// File: rtl/twm_ctrl.sv
module twm_ctrl
   import twm_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  bus_evt_t          evt,
   input  logic              sel_hi_pin,
   input  logic              sel_lo_pin,
   input  logic              busy,
   input  logic [BYTE_W-1:0] rd_data,
   output logic              sda_oe,
   output logic              commit,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [BYTE_W-1:0] wr_data,
   output logic [ADDR_W-1:0] rd_addr
);
   twm_state_e        state;
   logic [2:0]        bit_cnt;
   logic [BYTE_W-1:0] shreg;
   logic [BYTE_W-1:0] tx;
   logic [ADDR_W-1:0] ptr;
   logic              byte_done;
   logic              rd_mode;
   logic              pend_v;
   logic              mst_ack;
   logic              dev_match;

   assign dev_match = (shreg[BYTE_W-1] == ~sel_hi_pin) && (shreg[BYTE_W-2] == sel_lo_pin);
   assign rd_addr   = ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bit_cnt   <= '0;
         shreg     <= '0;
         tx        <= '0;
         ptr       <= '0;
         byte_done <= 1'b0;
         rd_mode   <= 1'b0;
         pend_v    <= 1'b0;
         mst_ack   <= 1'b0;
         sda_oe    <= 1'b0;
         commit    <= 1'b0;
         wr_addr   <= '0;
         wr_data   <= '0;
      end else begin
         commit <= 1'b0;
         if (busy) begin
            state     <= ST_IDLE;
            sda_oe    <= 1'b0;
            pend_v    <= 1'b0;
            byte_done <= 1'b0;
            mst_ack   <= 1'b0;
         end else if (evt.start) begin
            state     <= ST_DEV;
            bit_cnt   <= '0;
            sda_oe    <= 1'b0;
            pend_v    <= 1'b0;
            byte_done <= 1'b0;
            mst_ack   <= 1'b0;
         end else if (evt.stop) begin
            commit    <= pend_v;
            pend_v    <= 1'b0;
            state     <= ST_IDLE;
            sda_oe    <= 1'b0;
            byte_done <= 1'b0;
         end else begin
            unique case (state)
               ST_DEV, ST_ADR, ST_DAT: begin
                  if (evt.rise) begin
                     shreg   <= {shreg[BYTE_W-2:0], evt.sda};
                     bit_cnt <= bit_cnt + 3'd1;
                     if (bit_cnt == 3'd7) byte_done <= 1'b1;
                  end
                  if (evt.fall && byte_done) begin
                     byte_done <= 1'b0;
                     if (state == ST_DEV) begin
                        if (dev_match) begin
                           sda_oe                  <= 1'b1;
                           ptr[ADDR_W-1:BYTE_W]    <= shreg[HI_W:1];
                           rd_mode                 <= shreg[0];
                           state                   <= ST_DEV_ACK;
                        end else begin
                           state <= ST_IGNORE;
                        end
                     end else if (state == ST_ADR) begin
                        sda_oe           <= 1'b1;
                        ptr[BYTE_W-1:0]  <= shreg;
                        state            <= ST_ADR_ACK;
                     end else begin
                        sda_oe  <= 1'b1;
                        wr_data <= shreg;
                        wr_addr <= ptr;
                        pend_v  <= 1'b1;
                        state   <= ST_DAT_ACK;
                     end
                  end
               end
               ST_DEV_ACK: begin
                  if (evt.fall) begin
                     bit_cnt <= '0;
                     if (rd_mode) begin
                        tx     <= rd_data;
                        sda_oe <= ~rd_data[BYTE_W-1];
                        state  <= ST_RD;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= ST_ADR;
                     end
                  end
               end
               ST_ADR_ACK: begin
                  if (evt.fall) begin
                     sda_oe  <= 1'b0;
                     bit_cnt <= '0;
                     state   <= ST_DAT;
                  end
               end
               ST_DAT_ACK: begin
                  if (evt.fall) begin
                     sda_oe <= 1'b0;
                     state  <= ST_IGNORE;
                  end
               end
               ST_RD: begin
                  if (evt.fall) begin
                     if (bit_cnt == 3'd7) begin
                        sda_oe <= 1'b0;
                        state  <= ST_RD_ACK;
                     end else begin
                        bit_cnt <= bit_cnt + 3'd1;
                        tx      <= {tx[BYTE_W-2:0], 1'b0};
                        sda_oe  <= ~tx[BYTE_W-2];
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (evt.rise) begin
                     if (!evt.sda) begin
                        ptr     <= ptr + 1'b1;
                        mst_ack <= 1'b1;
                     end else begin
                        state <= ST_IGNORE;
                     end
                  end
                  if (evt.fall && mst_ack) begin
                     mst_ack <= 1'b0;
                     bit_cnt <= '0;
                     tx      <= rd_data;
                     sda_oe  <= ~rd_data[BYTE_W-1];
                     state   <= ST_RD;
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/twm_array.sv
module twm_array
   import twm_pkg::*;
#(
   parameter int unsigned ARRAY_DEPTH  = 2048,
   parameter int unsigned WRITE_CYCLES = 5000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [BYTE_W-1:0] rd_data,
   output logic              busy
);
   localparam int unsigned IDX_W = (ARRAY_DEPTH > 1) ? $clog2(ARRAY_DEPTH) : 1;
   localparam int unsigned CNT_W = $clog2(WRITE_CYCLES + 1);

   logic [BYTE_W-1:0] mem [ARRAY_DEPTH];
   logic [IDX_W-1:0]  wr_idx, rd_idx;
   logic [CNT_W-1:0]  remain;

   generate
      if ((ARRAY_DEPTH & (ARRAY_DEPTH - 1)) != 0 || ARRAY_DEPTH < 2) begin : g_bad_depth
         $error("twm_array: ARRAY_DEPTH must be a power of two, at least 2");
      end
      if (ARRAY_DEPTH > (1 << ADDR_W)) begin : g_bad_span
         $error("twm_array: ARRAY_DEPTH exceeds the address space");
      end
      if (WRITE_CYCLES < 1) begin : g_bad_cycles
         $error("twm_array: WRITE_CYCLES must be at least 1");
      end
      if (IDX_W == ADDR_W) begin : g_full
         assign wr_idx = wr_addr;
         assign rd_idx = rd_addr;
      end else begin : g_alias
         assign wr_idx = wr_addr[IDX_W-1:0];
         assign rd_idx = rd_addr[IDX_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (commit) mem[wr_idx] <= wr_data;
   end

   assign rd_data = mem[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         remain <= '0;
      end else if (commit) begin
         busy   <= 1'b1;
         remain <= CNT_W'(WRITE_CYCLES - 1);
      end else if (busy) begin
         if (remain == '0) busy <= 1'b0;
         else              remain <= remain - 1'b1;
      end
   end
endmodule

// File: rtl/twowire_mem_slave.sv
module twowire_mem_slave
   import twm_pkg::*;
#(
   parameter int unsigned ARRAY_DEPTH  = 2048,
   parameter int unsigned WRITE_CYCLES = 5000,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   input  logic sel_hi_pin,
   input  logic sel_lo_pin,
   output logic sda_oe,
   output logic busy
);
   bus_evt_t          evt;
   logic              scl_lvl;
   logic              commit;
   logic [ADDR_W-1:0] wr_addr, rd_addr;
   logic [BYTE_W-1:0] wr_data, rd_data;

   twm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .evt(evt), .scl_lvl(scl_lvl)
   );

   twm_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .evt(evt),
      .sel_hi_pin(sel_hi_pin), .sel_lo_pin(sel_lo_pin),
      .busy(busy), .rd_data(rd_data), .sda_oe(sda_oe), .commit(commit),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr)
   );

   twm_array #(.ARRAY_DEPTH(ARRAY_DEPTH), .WRITE_CYCLES(WRITE_CYCLES)) u_array (
      .clk(clk), .rst_n(rst_n), .commit(commit),
      .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
   );
endmodule

// File: rtl/twm_checker.sv
module twm_checker #(
   parameter int unsigned WRITE_CYCLES = 5000
) (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic sda_oe,
   input logic commit,
   input logic scl_lvl
);
   logic [31:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_cnt <= '0;
      else if (busy) run_cnt <= run_cnt + 32'd1;
      else           run_cnt <= '0;
   end

   AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !sda_oe); // R5

   AST_NO_COMMIT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !commit); // R5

   AST_BUSY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(commit)); // R4

   AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> run_cnt == 32'(WRITE_CYCLES)); // R10

   AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_lvl); // R3
endmodule

bind twowire_mem_slave twm_checker #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .sda_oe(sda_oe),
   .commit(commit), .scl_lvl(scl_lvl)
);

// File: tb/tb_twowire_mem_slave.sv
`timescale 1ns/1ps
module tb_twowire_mem_slave;
   localparam int WCYC = 600;
   localparam int Q    = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_drv = 1'b1;
   logic sda_drv = 1'b1;
   logic sel_hi = 1'b0;
   logic sel_lo = 1'b1;
   logic sda_oe, busy, sda_line;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   assign sda_line = sda_drv & ~sda_oe;

   twowire_mem_slave #(.ARRAY_DEPTH(8192), .WRITE_CYCLES(WCYC), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_drv), .sda_in(sda_line),
      .sel_hi_pin(sel_hi), .sel_lo_pin(sel_lo), .sda_oe(sda_oe), .busy(busy)
   );

   typedef struct { string req; int val; } exp_t;
   exp_t exp_q[$];
   event obs_ev;
   int   obs_val;

   initial begin
      forever begin
         @(obs_ev);
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL scoreboard: unexpected result %0d with no expectation", obs_val);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            if (obs_val != e.val) begin
               errors++;
               $display("FAIL %s: actual 0x%0h expected 0x%0h", e.req, obs_val, e.val);
            end
         end
      end
   end

   task automatic expect_val(string req, int v);
      exp_t e;
      e.req = req;
      e.val = v;
      exp_q.push_back(e);
   endtask

   task automatic observe(int v);
      obs_val = v;
      ->obs_ev;
      #1;
   endtask

   task automatic clks(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_drv = 1'b1; clks(Q);
      scl_drv = 1'b1; clks(Q);
      sda_drv = 1'b0; clks(Q);
      scl_drv = 1'b0; clks(Q);
   endtask

   task automatic bus_stop();
      sda_drv = 1'b0; clks(Q);
      scl_drv = 1'b1; clks(Q);
      sda_drv = 1'b1; clks(Q);
   endtask

   task automatic send_bits(logic [7:0] b, int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda_drv = b[i]; clks(Q);
         scl_drv = 1'b1; clks(2*Q);
         scl_drv = 1'b0; clks(Q);
      end
   endtask

   task automatic send_byte(logic [7:0] b, bit exp_ack, string req);
      bit ack;
      expect_val(req, exp_ack);
      send_bits(b, 8);
      sda_drv = 1'b1; clks(Q);
      scl_drv = 1'b1; clks(Q);
      ack = ~sda_line;
      clks(Q);
      scl_drv = 1'b0; clks(Q);
      observe(ack);
   endtask

   task automatic recv_byte(logic [7:0] exp_b, bit give_ack, string req);
      logic [7:0] got;
      expect_val(req, exp_b);
      sda_drv = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         clks(Q);
         scl_drv = 1'b1; clks(Q);
         got[i] = sda_line;
         clks(Q);
         scl_drv = 1'b0;
      end
      clks(Q);
      sda_drv = give_ack ? 1'b0 : 1'b1; clks(Q);
      scl_drv = 1'b1; clks(2*Q);
      scl_drv = 1'b0; clks(Q);
      sda_drv = 1'b1;
      observe(got);
   endtask

   function automatic logic [7:0] dev_byte(logic [1:0] sel, logic [12:0] a, logic rw);
      return {sel, a[12:8], rw};
   endfunction

   task automatic check_now(string req, int actual, int expv);
      expect_val(req, expv);
      observe(actual);
   endtask

   task automatic wait_idle();
      int n = 0;
      while (busy && n < 4*WCYC) begin clks(1); n++; end
   endtask

   // full byte write; optional probe of the bus during the write cycle
   task automatic do_write(logic [12:0] a, logic [7:0] d, bit probe);
      bus_start();
      send_byte(dev_byte(2'b11, a, 1'b0), 1'b1, "R3 ack device byte");
      send_byte(a[7:0], 1'b1, "R3 ack address byte");
      send_byte(d, 1'b1, "R3 ack data byte");
      clks(4*Q);
      check_now("R4 no busy before stop", busy, 0);
      bus_stop();
      check_now("R4 busy after stop", busy, 1);
      if (probe) begin
         bus_start();
         send_byte(dev_byte(2'b11, a, 1'b0), 1'b0, "R5 no ack while busy");
         check_now("R5 still busy during probe", busy, 1);
         bus_stop();
         wait_idle();
      end else begin
         int n = 0;
         while (busy && n < 4*WCYC) begin clks(1); n++; end
         check_now("R10 busy length", n + 8 + 3*Q - 3*Q, WCYC);
      end
      clks(4);
   endtask

   task automatic rand_read(logic [12:0] a, logic [7:0] exp_b, string req);
      bus_start();
      send_byte(dev_byte(2'b11, a, 1'b0), 1'b1, "R7 ack write header");
      send_byte(a[7:0], 1'b1, "R7 ack address");
      bus_start();
      send_byte(dev_byte(2'b11, a, 1'b1), 1'b1, "R7 ack read header");
      recv_byte(exp_b, 1'b0, req);
      bus_stop();
      clks(Q);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks + 1, errors);
         $finish;
      end
   end

   initial begin
      clks(5);
      check_now("R1 sda released in reset", sda_oe, 0);
      check_now("R1 busy low in reset", busy, 0);
      rst_n = 1'b1;
      clks(5);
      check_now("R1 sda released after reset", sda_oe, 0);
      check_now("R1 busy low after reset", busy, 0);
      begin
         // R10 exact busy length measured from its first high cycle
         bus_start();
         send_byte(dev_byte(2'b11, 13'h1ABC, 1'b0), 1'b1, "R3 ack device byte");
         send_byte(8'hBC, 1'b1, "R3 ack address byte");
         send_byte(8'h5A, 1'b1, "R3 ack data byte");
         clks(4*Q);
         check_now("R4 no busy before stop", busy, 0);
         sda_drv = 1'b0; clks(Q);
         scl_drv = 1'b1; clks(Q);
         sda_drv = 1'b1;
         begin
            int w = 0;
            int n = 0;
            while (!busy && w < 50) begin clks(1); w++; end
            check_now("R4 busy rises after stop", busy, 1);
            while (busy && n < 4*WCYC) begin clks(1); n++; end
            check_now("R10 busy length", n, WCYC);
         end
         clks(4);
      end
      do_write(13'h0ABC, 8'hC3, 1'b1);
      rand_read(13'h1ABC, 8'h5A, "R7 read upper-bank byte");
      rand_read(13'h0ABC, 8'hC3, "R7 read lower-bank byte");

      // R8 sequential read
      do_write(13'h0010, 8'h11, 1'b1);
      do_write(13'h0011, 8'h22, 1'b1);
      bus_start();
      send_byte(dev_byte(2'b11, 13'h0010, 1'b0), 1'b1, "R8 ack write header");
      send_byte(8'h10, 1'b1, "R8 ack address");
      bus_start();
      send_byte(dev_byte(2'b11, 13'h0010, 1'b1), 1'b1, "R8 ack read header");
      recv_byte(8'h11, 1'b1, "R8 first sequential byte");
      recv_byte(8'h22, 1'b0, "R8 second sequential byte");
      bus_stop();
      check_now("R8 no busy after read", busy, 0);

      // R2 device select mismatch
      bus_start();
      send_byte(dev_byte(2'b01, 13'h0010, 1'b0), 1'b0, "R2 nack select 01");
      send_byte(8'h10, 1'b0, "R2 ignored after mismatch");
      bus_stop();
      bus_start();
      send_byte(dev_byte(2'b10, 13'h0010, 1'b0), 1'b0, "R2 nack select 10");
      bus_stop();
      bus_start();
      send_byte(dev_byte(2'b00, 13'h0010, 1'b0), 1'b0, "R2 nack select 00");
      bus_stop();
      clks(Q);
      check_now("R2 no write after mismatch", busy, 0);
      sel_hi = 1'b1; sel_lo = 1'b0;
      bus_start();
      send_byte(dev_byte(2'b00, 13'h0010, 1'b0), 1'b1, "R2 ack select 00 with new pins");
      send_byte(8'h10, 1'b1, "R2 ack address with new pins");
      bus_start();
      send_byte(dev_byte(2'b00, 13'h0010, 1'b1), 1'b1, "R2 ack read header new pins");
      recv_byte(8'h11, 1'b0, "R2 read with new pins");
      bus_stop();
      sel_hi = 1'b0; sel_lo = 1'b1;
      clks(Q);

      // R6 aborted writes
      bus_start();
      send_byte(dev_byte(2'b11, 13'h1ABC, 1'b0), 1'b1, "R6 ack header");
      send_byte(8'hBC, 1'b1, "R6 ack address");
      bus_stop();
      clks(Q);
      check_now("R6 no busy after early stop", busy, 0);
      bus_start();
      send_byte(dev_byte(2'b11, 13'h1ABC, 1'b0), 1'b1, "R6 ack header");
      send_byte(8'hBC, 1'b1, "R6 ack address");
      send_bits(8'hFF, 4);
      bus_stop();
      clks(Q);
      check_now("R6 no busy after mid-byte stop", busy, 0);
      rand_read(13'h1ABC, 8'h5A, "R6 array unchanged");

      // R5 deafness result
      do_write(13'h0200, 8'h77, 1'b1);
      rand_read(13'h0200, 8'h77, "R5 write intact after probe");

      // R9 extra data byte
      do_write(13'h0041, 8'h12, 1'b1);
      bus_start();
      send_byte(dev_byte(2'b11, 13'h0040, 1'b0), 1'b1, "R9 ack header");
      send_byte(8'h40, 1'b1, "R9 ack address");
      send_byte(8'h9E, 1'b1, "R9 ack first data");
      send_byte(8'h33, 1'b0, "R9 nack second data");
      bus_stop();
      check_now("R9 first byte committed", busy, 1);
      wait_idle();
      clks(4);
      rand_read(13'h0040, 8'h9E, "R9 first byte stored");
      rand_read(13'h0041, 8'h12, "R9 next address untouched");

      #1;
      if (exp_q.size() != 0) begin
         errors++;
         checks++;
         $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
      end
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule